// File: doc/BRIEF.md
# Debug Context Register Access Guard

This block holds the two context registers that a hart's trigger module compares against, one for supervisor software and one for the hypervisor, and checks every access made to them. Two further addresses have no storage of their own: a machine-level alias of the hypervisor context and a machine-level alias of the supervisor context. Each request carries a 12-bit register address, a write enable, write data, the current privilege level, the virtualization bit and the context-enable bit from the machine-level and hypervisor-level state-enable registers. The block answers in the same cycle with read data and at most one of two trap flags: illegal instruction or virtual instruction.

Parameters choose the register width (32 or 64) and whether the hypervisor, supervisor and state-enable extensions exist. A write lands on the next rising clock edge, and only when the access raises no trap. Decoding of other registers, trigger matching and trap delivery belong to the surrounding register file.

Top module: `dbg_ctx_csr_guard`

## Requirements
- R1: After reset both context registers hold zero, and a trap-free read of any of the four context addresses returns zero.
- R2: The supervisor context at address 0x5A8 keeps the low 16 bits of a write when XLEN is 32 and the low 34 bits when XLEN is 64. The other bits are dropped and read back as zero.
- R3: The hypervisor context at address 0x6A8 keeps the low 6 bits (XLEN 32) or 13 bits (XLEN 64) of a write, plus one more bit when the hypervisor extension is present. Reads are zero-extended.
- R4: Address 0x7A8 reads and writes the hypervisor context storage.
- R5: Address 0x7AA reads and writes the supervisor context storage.
- R6: Privilege is coded 0 = U, 1 = S, 3 = M (code 2 is never driven). With the state-enable extension present, a context access from a privilege other than M while the machine-level enable bit is 0 raises illegal instruction. This check wins over every other check.
- R7: With the state-enable extension present and R6 not firing, a context access with V = 1 while the hypervisor-level enable bit is 0 raises virtual instruction.
- R8: Once R6 and R7 pass, any access to 0x7AA raises illegal instruction when the supervisor extension is absent.
- R9: For 0x7AA, non-virtual S counts as HS. An access that passes R6 to R8 from U raises virtual instruction when V = 1 and illegal instruction when V = 0. From S or M it raises no trap.
- R10: A write that raises a trap leaves both context registers unchanged.
- R11: Read data is zero and no trap is raised when no request is valid or the address is not one of the four context addresses. Read data is also zero while a trap is raised. Such accesses change no register.
- R12: Without the state-enable extension both enable inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is requested this cycle |
| req_addr | input | 12 | Register address of the access |
| req_we | input | 1 | The access is a write |
| req_wdata | input | XLEN | Write data |
| req_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Hart is virtualized |
| m_ctx_en | input | 1 | Context-enable bit of the machine-level state-enable register |
| h_ctx_en | input | 1 | Context-enable bit of the hypervisor-level state-enable register |
| rdata | output | XLEN | Read data, zero-extended |
| trap_ill | output | 1 | Illegal-instruction trap |
| trap_virt | output | 1 | Virtual-instruction trap |

## Verification
The bench builds two copies that share their inputs. The first uses XLEN 64 with the hypervisor, supervisor and state-enable extensions present, so the 34-bit and 14-bit masks and both enable gates are exercised. The second uses XLEN 32 with none of the extensions, which brings the 16-bit and 6-bit masks, the ignored enable inputs and the always-trapping supervisor alias within reach. A sweep runs over every combination of address, privilege, virtualization and both enable bits. Each step is a write, and an arithmetic model of both registers predicts every trap and every read.

// File: rtl/dbg_ctx_pkg.sv
// Shared constants and types for the debug context access guard.
// Assumes a 12-bit register address space and 2-bit privilege codes.
package dbg_ctx_pkg;

    localparam logic [11:0] ADDR_SUP_CTX  = 12'h5A8;
    localparam logic [11:0] ADDR_HYP_CTX  = 12'h6A8;
    localparam logic [11:0] ADDR_HYP_ALI  = 12'h7A8;
    localparam logic [11:0] ADDR_SUP_ALI  = 12'h7AA;

    // PRIV_HS is never driven on the port; it is used only as the effective level.
    typedef enum logic [1:0] {
        PRIV_U  = 2'd0,
        PRIV_S  = 2'd1,
        PRIV_HS = 2'd2,
        PRIV_M  = 2'd3
    } priv_e;

    typedef struct packed {
        logic sup_direct;
        logic hyp_direct;
        logic hyp_alias;
        logic sup_alias;
    } ctx_sel_t;

    function automatic int sup_ctx_width(input int xlen);
        return (xlen == 32) ? 16 : 34;
    endfunction

    function automatic int hyp_ctx_width(input int xlen, input bit has_hyp);
        return ((xlen == 32) ? 6 : 13) + (has_hyp ? 1 : 0);
    endfunction

endpackage

// File: rtl/dbg_ctx_decode.sv
// Address decoder: flags which of the four context addresses is selected.
// Assumes exact 12-bit address matches; anything else selects nothing.
module dbg_ctx_decode
    import dbg_ctx_pkg::*;
(
    input  logic [11:0] addr,
    output ctx_sel_t    sel,
    output logic        hit
);

    // Compare the address against each context location.
    always_comb begin
        sel.sup_direct = (addr == ADDR_SUP_CTX);
        sel.hyp_direct = (addr == ADDR_HYP_CTX);
        sel.hyp_alias  = (addr == ADDR_HYP_ALI);
        sel.sup_alias  = (addr == ADDR_SUP_ALI);
    end

    // Any context address at all.
    assign hit = |sel;

endmodule

// File: rtl/dbg_ctx_perm.sv
// Permission checker: decides which trap, if any, an access raises.
// Order: machine enable gate, hypervisor enable gate, supervisor presence,
// then the effective-privilege rule of the supervisor alias.
module dbg_ctx_perm
    import dbg_ctx_pkg::*;
#(
    parameter bit HAS_SUP     = 1'b1,
    parameter bit HAS_STATEEN = 1'b1
) (
    input  logic       valid,
    input  ctx_sel_t   sel,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       m_en,
    input  logic       h_en,
    output logic       ill,
    output logic       vir
);

    priv_e cur_priv;
    priv_e eff_priv;
    logic  any_ctx;
    logic  gate_m_block;
    logic  gate_h_block;

    // Non-virtual S is treated as HS for the supervisor alias.
    always_comb begin
        cur_priv = priv_e'(priv);
        eff_priv = (cur_priv == PRIV_S && !virt) ? PRIV_HS : cur_priv;
    end

    // Enable-gate conditions, only meaningful when the extension exists.
    always_comb begin
        any_ctx      = valid && (|sel);
        gate_m_block = HAS_STATEEN && (cur_priv != PRIV_M) && !m_en;
        gate_h_block = HAS_STATEEN && virt && !h_en;
    end

    // Priority chain that selects the single trap.
    always_comb begin
        ill = 1'b0;
        vir = 1'b0;
        if (any_ctx) begin
            if (gate_m_block) begin
                ill = 1'b1;
            end else if (gate_h_block) begin
                vir = 1'b1;
            end else if (sel.sup_alias) begin
                if (!HAS_SUP) begin
                    ill = 1'b1;
                end else if (eff_priv < PRIV_S) begin
                    vir = virt;
                    ill = !virt;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_ctx_store.sv
// One context register: XLEN wide, with bits at and above W held at zero.
// Assumes W <= XLEN; the unused upper flops are constant and trimmed.
module dbg_ctx_store #(
    parameter int XLEN = 64,
    parameter int W    = 34
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wen,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] q
);

    function automatic logic [XLEN-1:0] low_ones(input int n);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) m[i] = (i < n);
        return m;
    endfunction

    localparam logic [XLEN-1:0] KEEP = low_ones(W);

    // Masked register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wen)
            q <= wdata & KEEP;
    end

endmodule

// File: rtl/dbg_ctx_csr_guard.sv
// Top: debug context registers with state-enable gated access checks.
// Traps and read data are combinational; writes commit on the next edge
// only for trap-free accesses. Privilege code 2 is assumed never driven.
module dbg_ctx_csr_guard
    import dbg_ctx_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit HAS_HYP     = 1'b1,
    parameter bit HAS_SUP     = 1'b1,
    parameter bit HAS_STATEEN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic            req_we,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [1:0]      req_priv,
    input  logic            req_virt,
    input  logic            m_ctx_en,
    input  logic            h_ctx_en,
    output logic [XLEN-1:0] rdata,
    output logic            trap_ill,
    output logic            trap_virt
);

    localparam int SUP_W = sup_ctx_width(XLEN);
    localparam int HYP_W = hyp_ctx_width(XLEN, HAS_HYP);

    ctx_sel_t        sel;
    logic            hit;
    logic            ok;
    logic            to_sup;
    logic            to_hyp;
    logic            wen_sup;
    logic            wen_hyp;
    logic [XLEN-1:0] sup_q;
    logic [XLEN-1:0] hyp_q;

    dbg_ctx_decode u_decode (
        .addr (req_addr),
        .sel  (sel),
        .hit  (hit)
    );

    dbg_ctx_perm #(
        .HAS_SUP     (HAS_SUP),
        .HAS_STATEEN (HAS_STATEEN)
    ) u_perm (
        .valid (req_valid),
        .sel   (sel),
        .priv  (req_priv),
        .virt  (req_virt),
        .m_en  (m_ctx_en),
        .h_en  (h_ctx_en),
        .ill   (trap_ill),
        .vir   (trap_virt)
    );

    // Route the access to a storage target and qualify it.
    always_comb begin
        to_sup  = sel.sup_direct || sel.sup_alias;
        to_hyp  = sel.hyp_direct || sel.hyp_alias;
        ok      = req_valid && hit && !trap_ill && !trap_virt;
        wen_sup = ok && req_we && to_sup;
        wen_hyp = ok && req_we && to_hyp;
    end

    dbg_ctx_store #(.XLEN(XLEN), .W(SUP_W)) u_sup_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (wen_sup),
        .wdata (req_wdata),
        .q     (sup_q)
    );

    dbg_ctx_store #(.XLEN(XLEN), .W(HYP_W)) u_hyp_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (wen_hyp),
        .wdata (req_wdata),
        .q     (hyp_q)
    );

    // Read mux: zero unless the access is valid, decoded and trap-free.
    always_comb begin
        rdata = '0;
        if (ok && to_sup)
            rdata = sup_q;
        else if (ok && to_hyp)
            rdata = hyp_q;
    end

endmodule

// File: rtl/dbg_ctx_csr_guard_chk.sv
// Checker for dbg_ctx_csr_guard, bound to every instance of the top.
module dbg_ctx_csr_guard_chk
    import dbg_ctx_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit HAS_STATEEN = 1'b1,
    parameter int SUP_W       = 34
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [11:0]     req_addr,
    input logic            req_we,
    input logic [1:0]      req_priv,
    input logic            m_ctx_en,
    input logic            trap_ill,
    input logic            trap_virt,
    input logic [XLEN-1:0] rdata,
    input logic [XLEN-1:0] sup_q,
    input logic [XLEN-1:0] hyp_q
);

    logic is_ctx;
    assign is_ctx = (req_addr == ADDR_SUP_CTX) || (req_addr == ADDR_HYP_CTX) ||
                    (req_addr == ADDR_HYP_ALI) || (req_addr == ADDR_SUP_ALI);

    // R6: at most one trap kind at a time.
    assert_one_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_ill && trap_virt));

    // R6: machine enable gate forces illegal instruction.
    assert_mgate_ill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_STATEEN && req_valid && is_ctx && req_priv != 2'd3 && !m_ctx_en) |-> trap_ill);

    // R11: no trap without a valid context access.
    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && is_ctx) |-> (!trap_ill && !trap_virt && rdata == '0));

    // R10: a trapped write leaves both registers untouched.
    assert_trap_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && (trap_ill || trap_virt)) |=> ($stable(sup_q) && $stable(hyp_q)));

    // R2: read data never exceeds the widest context register.
    assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata >> SUP_W) == '0);

endmodule

bind dbg_ctx_csr_guard dbg_ctx_csr_guard_chk #(
    .XLEN        (XLEN),
    .HAS_STATEEN (HAS_STATEEN),
    .SUP_W       (SUP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .req_priv  (req_priv),
    .m_ctx_en  (m_ctx_en),
    .trap_ill  (trap_ill),
    .trap_virt (trap_virt),
    .rdata     (rdata),
    .sup_q     (sup_q),
    .hyp_q     (hyp_q)
);

// File: tb/dbg_ctx_csr_guard_tb.sv
// Bench: two configurations share inputs; a model predicts traps and reads.
module dbg_ctx_csr_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_priv = 2'd3;
    logic        req_virt = 1'b0;
    logic        m_ctx_en = 1'b1;
    logic        h_ctx_en = 1'b1;
    logic [63:0] d_rdata;
    logic        d_ill, d_vir;
    logic [31:0] a_rdata;
    logic        a_ill, a_vir;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] dm_sup = '0, dm_hyp = '0, am_sup = '0, am_hyp = '0;
    localparam logic [63:0] D_SUP_M = (64'd1 << 34) - 1;
    localparam logic [63:0] D_HYP_M = (64'd1 << 14) - 1;
    localparam logic [63:0] A_SUP_M = (64'd1 << 16) - 1;
    localparam logic [63:0] A_HYP_M = (64'd1 << 6) - 1;

    always #5 clk = ~clk;

    dbg_ctx_csr_guard #(.XLEN(64), .HAS_HYP(1'b1), .HAS_SUP(1'b1), .HAS_STATEEN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_priv(req_priv), .req_virt(req_virt),
        .m_ctx_en(m_ctx_en), .h_ctx_en(h_ctx_en),
        .rdata(d_rdata), .trap_ill(d_ill), .trap_virt(d_vir));

    dbg_ctx_csr_guard #(.XLEN(32), .HAS_HYP(1'b0), .HAS_SUP(1'b0), .HAS_STATEEN(1'b0)) u_alt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata[31:0]), .req_priv(req_priv), .req_virt(req_virt),
        .m_ctx_en(m_ctx_en), .h_ctx_en(h_ctx_en),
        .rdata(a_rdata), .trap_ill(a_ill), .trap_virt(a_vir));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_ctx(input logic [11:0] a);
        return a == 12'h5A8 || a == 12'h6A8 || a == 12'h7A8 || a == 12'h7AA;
    endfunction

    // Expected traps from the requirement rules R6..R9, R11, R12.
    task automatic model_trap(input logic [11:0] a, input bit vld, input logic [1:0] p,
                              input bit v, input bit mg, input bit hg,
                              input bit stateen, input bit sup,
                              output bit ei, output bit ev);
        ei = 1'b0; ev = 1'b0;
        if (vld && is_ctx(a)) begin
            if (stateen && p != 2'd3 && !mg) ei = 1'b1;
            else if (stateen && v && !hg) ev = 1'b1;
            else if (a == 12'h7AA) begin
                if (!sup) ei = 1'b1;
                else if (p == 2'd0) begin ev = v; ei = !v; end
            end
        end
    endtask

    function automatic string trap_tag(input logic [11:0] a, input bit vld, input bit stateen,
                                       input bit sup, input bit ei, input bit ev);
        if (!vld || !is_ctx(a)) return "R11";
        if (stateen && (ei || ev)) return ei ? "R6" : "R7";
        if (a == 12'h7AA) return sup ? "R9" : "R8";
        return stateen ? "R6" : "R12";
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        case (a)
            12'h5A8: return "R2";
            12'h6A8: return "R3";
            12'h7A8: return "R4";
            12'h7AA: return "R5";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] pick(input logic [11:0] a, input logic [63:0] s,
                                         input logic [63:0] h);
        if (a == 12'h5A8 || a == 12'h7AA) return s;
        if (a == 12'h6A8 || a == 12'h7A8) return h;
        return '0;
    endfunction

    // One access: drive at falling edge, check before the rising edge, update model.
    task automatic access(input logic [11:0] a, input bit vld, input bit we,
                          input logic [63:0] wd, input logic [1:0] p, input bit v,
                          input bit mg, input bit hg, input string rtag);
        bit ei, ev, ai, av;
        logic [63:0] exp;
        string t;
        @(negedge clk);
        req_valid = vld; req_addr = a; req_we = we; req_wdata = wd;
        req_priv = p; req_virt = v; m_ctx_en = mg; h_ctx_en = hg;
        #2;
        model_trap(a, vld, p, v, mg, hg, 1'b1, 1'b1, ei, ev);
        model_trap(a, vld, p, v, mg, hg, 1'b0, 1'b0, ai, av);
        t = trap_tag(a, vld, 1'b1, 1'b1, ei, ev);
        check(d_ill == ei, t, "dut illegal", 64'(d_ill), 64'(ei));
        check(d_vir == ev, t, "dut virtual", 64'(d_vir), 64'(ev));
        t = trap_tag(a, vld, 1'b0, 1'b0, ai, av);
        check(a_ill == ai, t, "alt illegal", 64'(a_ill), 64'(ai));
        check(a_vir == av, t, "alt virtual", 64'(a_vir), 64'(av));
        t = (rtag != "") ? rtag : read_tag(a);
        exp = (!vld || ei || ev) ? 64'd0 : pick(a, dm_sup, dm_hyp);
        check(d_rdata == exp, t, "dut rdata", d_rdata, exp);
        exp = (!vld || ai || av) ? 64'd0 : pick(a, am_sup, am_hyp);
        check(64'(a_rdata) == exp, t, "alt rdata", 64'(a_rdata), exp);
        if (vld && we && !ei && !ev) begin
            if (a == 12'h5A8 || a == 12'h7AA) dm_sup = wd & D_SUP_M;
            if (a == 12'h6A8 || a == 12'h7A8) dm_hyp = wd & D_HYP_M;
        end
        if (vld && we && !ai && !av) begin
            if (a == 12'h5A8 || a == 12'h7AA) am_sup = wd & A_SUP_M;
            if (a == 12'h6A8 || a == 12'h7A8) am_hyp = wd & A_HYP_M;
        end
    endtask

    initial begin
        logic [11:0] addrs [7];
        logic [63:0] seed;
        addrs = '{12'h5A8, 12'h6A8, 12'h7A8, 12'h7AA, 12'h7A9, 12'h5A9, 12'h000};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values through every context address.
        for (int i = 0; i < 4; i++) access(addrs[i], 1, 0, '0, 2'd3, 0, 1, 1, "R1");
        // R2, R3: all-ones writes are masked to the register widths.
        access(12'h5A8, 1, 1, '1, 2'd3, 0, 1, 1, "R2");
        access(12'h5A8, 1, 0, '0, 2'd3, 0, 1, 1, "R2");
        access(12'h6A8, 1, 1, '1, 2'd3, 0, 1, 1, "R3");
        access(12'h6A8, 1, 0, '0, 2'd3, 0, 1, 1, "R3");
        // R4, R5: aliases write into and read from the direct registers.
        access(12'h7A8, 1, 1, 64'h1234, 2'd3, 0, 1, 1, "R4");
        access(12'h6A8, 1, 0, '0, 2'd3, 0, 1, 1, "R4");
        access(12'h7AA, 1, 1, 64'h3_0000_ABCD, 2'd1, 0, 1, 1, "R5");
        access(12'h5A8, 1, 0, '0, 2'd3, 0, 1, 1, "R5");
        // R10: trapped write from U with the machine gate closed changes nothing.
        access(12'h5A8, 1, 1, 64'h55, 2'd0, 0, 0, 1, "R10");
        access(12'h5A8, 1, 0, '0, 2'd3, 0, 1, 1, "R10");
        // R11: an invalid request is quiet and writes nothing.
        access(12'h6A8, 0, 1, 64'h7, 2'd0, 0, 0, 0, "R11");
        access(12'h6A8, 1, 0, '0, 2'd3, 0, 1, 1, "R11");
        // Full sweep of address, privilege, virtualization and both gates.
        seed = 64'h9E37_79B9_7F4A_7C15;
        for (int ai = 0; ai < 7; ai++)
            for (int pi = 0; pi < 3; pi++)
                for (int v = 0; v < 2; v++)
                    for (int g = 0; g < 4; g++) begin
                        logic [1:0] p;
                        p = (pi == 0) ? 2'd0 : (pi == 1) ? 2'd1 : 2'd3;
                        if (!(p == 2'd3 && v == 1)) begin
                            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
                            access(addrs[ai], 1, 1, seed, p, v[0], g[1], g[0], "");
                            access(addrs[ai % 4], 1, 0, '0, 2'd3, 0, 1, 1, "");
                        end
                    end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule